// File: doc/BRIEF.md
# MDIO Management Master

This block is a register-driven controller that runs clause-22 management frames to an external PHY over a two-wire serial bus. Software first programs a configuration word that holds a clock divisor and an interface enable. For a write it then loads sixteen data bits. Finally it writes a control word that carries the PHY address, the register address, a read or write opcode and an initiate bit. The block derives the management clock MDC from the system clock and shifts out the frame. For a read, it releases the data line and collects the PHY's answer. When the frame is over, the control word reports ready again. For a read, the collected value is then available in the read-data word. The bidirectional data pin is presented as separate output, output-enable and input signals.

The frame sequencer is a five-state machine. IDLE moves to PREAMBLE when an initiate is accepted. PREAMBLE moves to HEADER after 32 bits. HEADER, which carries the start code, opcode and both addresses, moves to TURN after 14 bits. TURN moves to DATA after 2 bits. DATA returns to IDLE after 16 bits. The state changes only on falling MDC edges.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset, word 0 (configuration) reads 0x0000001D (divisor 29, enable clear). Word 1 (control) reads 0x00000080 (ready set). Word 3 (read data) reads 0.
- R2: In word 0, bits 5:0 hold the divisor d and bit 6 the enable. During a frame, MDC has a period of 2*(d+1) clock cycles, with the low half first. MDC is held low whenever no frame runs.
- R3: In word 1, bits 28:24 hold the PHY address, bits 20:16 the register address, bit 15 the read opcode and bit 14 the write opcode, and all of these read back as written. Bit 11 is the initiate bit and always reads 0.
- R4: Ready (word 1 bit 7) reads 0 from the clock cycle after an accepted initiate write. It reads 1 again after 64 MDC periods.
- R5: Each frame starts with 32 ones, then 01, then the opcode (10 for read, 01 for write), then the PHY address and the register address, most significant bit first. mdio_o changes only on falling MDC edges.
- R6: A write frame continues with turnaround 10 and the 16 bits of word 2 (write data), most significant bit first. mdio_oe stays high for the whole write frame.
- R7: A read frame drops mdio_oe for the turnaround and the 16 data bits. mdio_i is sampled on rising MDC edges, and the result appears in word 3 bits 15:0 when ready returns.
- R8: A read to an absent PHY, with mdio_i held high, returns 0xFFFF. A scan of addresses 31 down to 0 finds exactly the one PHY that answers.
- R9: An initiate written while the enable is clear starts nothing. Ready stays 1, MDC stays low and mdio_oe stays low.
- R10: A control write that arrives while a frame runs is ignored completely. The frame goes on unchanged and the stored control fields keep their values.
- R11: An initiate with neither opcode bit set starts nothing. If both opcode bits are set, a read is performed.
- R12: Word 3 is read-only, so writes to it leave its value unchanged. Word 2 reads back the value last written to it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Word select: 0 config, 1 control, 2 write data, 3 read data |
| wr_data | input | 32 | Register write value |
| rd_data | output | 32 | Register read value for addr (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Serial data driven toward the PHY |
| mdio_oe | output | 1 | High while the block drives the data line |
| mdio_i | input | 1 | Serial data seen on the line |

## Verification
The hardest situation to reach from the ports is a control write that lands in the middle of a running frame. The frame must carry on bit-exact, and the stored fields must not move. The stimulus issues a second initiate with different addresses and opcode partway through a slow write frame. A per-clock model then confirms that every later MDC edge and data bit still follows the first frame. Reads rely on a bench PHY model that drives mdio_i only while mdio_oe is low, and holds it high otherwise. This covers both the present-PHY case and the absent-PHY case, and the 32-address scan runs at the fastest divisor.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREAMBLE,
        ST_HEADER,
        ST_TURN,
        ST_DATA
    } mdio_state_e;

    localparam int CTRL_PHY_LSB = 24;
    localparam int CTRL_REG_LSB = 16;
    localparam int CTRL_RD_BIT  = 15;
    localparam int CTRL_WR_BIT  = 14;
    localparam int CTRL_GO_BIT  = 11;
    localparam int CTRL_RDY_BIT = 7;
    localparam int CFG_EN_BIT   = 6;

    localparam logic [1:0] ADDR_CFG   = 2'd0;
    localparam logic [1:0] ADDR_CTRL  = 2'd1;
    localparam logic [1:0] ADDR_WDATA = 2'd2;
    localparam logic [1:0] ADDR_RDATA = 2'd3;

    localparam int PRE_LEN = 32;
    localparam int TA_LEN  = 2;

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise,
    output logic             fall
);

    logic [DIV_W-1:0] cnt_q;
    logic             wrap;

    assign wrap = run && (cnt_q == div);
    assign rise = wrap && !mdc;
    assign fall = wrap && mdc;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            mdc   <= ~mdc;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/mdio_engine.sv
module mdio_engine
    import mdio_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              op_rd,
    input  logic [ADDR_W-1:0] phy_addr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rise,
    input  logic              fall,
    input  logic              mdio_i,
    output logic              busy,
    output logic              is_rd,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic [DATA_W-1:0] rdata
);

    localparam int HDR_LEN = 4 + 2 * ADDR_W;
    localparam int TX_W    = HDR_LEN + TA_LEN + DATA_W;
    localparam int CNT_W   = $clog2(PRE_LEN + HDR_LEN + DATA_W + 1);

    mdio_state_e       state, state_nx;
    logic [CNT_W-1:0]  cnt_q;
    logic [TX_W-1:0]   tx_sr;
    logic [DATA_W-1:0] rx_sr;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (start) state_nx = ST_PREAMBLE;
            ST_PREAMBLE: if (fall && cnt_q == CNT_W'(PRE_LEN - 1)) state_nx = ST_HEADER;
            ST_HEADER:   if (fall && cnt_q == CNT_W'(HDR_LEN - 1)) state_nx = ST_TURN;
            ST_TURN:     if (fall && cnt_q == CNT_W'(TA_LEN - 1))  state_nx = ST_DATA;
            ST_DATA:     if (fall && cnt_q == CNT_W'(DATA_W - 1))  state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    // pin outputs
    always_comb begin
        mdio_o  = 1'b1;
        mdio_oe = 1'b0;
        unique case (state)
            ST_IDLE:     begin mdio_o = 1'b1;        mdio_oe = 1'b0;   end
            ST_PREAMBLE: begin mdio_o = 1'b1;        mdio_oe = 1'b1;   end
            ST_HEADER:   begin mdio_o = tx_sr[TX_W-1]; mdio_oe = 1'b1; end
            ST_TURN,
            ST_DATA:     begin mdio_o = tx_sr[TX_W-1]; mdio_oe = !is_rd; end
            default:     begin mdio_o = 1'b1;        mdio_oe = 1'b0;   end
        endcase
    end

    assign busy = (state != ST_IDLE);

    // datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tx_sr <= '0;
            rx_sr <= '0;
            rdata <= '0;
            is_rd <= 1'b0;
        end else begin
            if (state != state_nx)  cnt_q <= '0;
            else if (fall)          cnt_q <= cnt_q + 1'b1;

            if (state == ST_IDLE && start) begin
                is_rd <= op_rd;
                tx_sr <= {2'b01, (op_rd ? 2'b10 : 2'b01), phy_addr, reg_addr, 2'b10, wdata};
            end else if (fall && state != ST_IDLE && state != ST_PREAMBLE) begin
                tx_sr <= {tx_sr[TX_W-2:0], 1'b0};
            end

            if (rise && state == ST_DATA && is_rd)
                rx_sr <= {rx_sr[DATA_W-2:0], mdio_i};

            if (state == ST_DATA && state_nx == ST_IDLE && is_rd)
                rdata <= rx_sr;
        end
    end

endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
    import mdio_pkg::*;
#(
    parameter int DIV_W     = 6,
    parameter int DIV_RESET = 29,
    parameter int ADDR_W    = 5,
    parameter int DATA_W    = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  addr,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);

    logic [DIV_W-1:0]  cfg_div;
    logic              cfg_en;
    logic [ADDR_W-1:0] phy_q, reg_q;
    logic              op_rd_q, op_wr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata;
    logic              busy, eng_rd, rise, fall;
    logic              ctrl_wr, start_req;
    logic              unused_bits;

    assign unused_bits = ^{wr_data[31:CTRL_PHY_LSB+ADDR_W], wr_data[CTRL_PHY_LSB-1:CTRL_REG_LSB+ADDR_W],
                           wr_data[13:12], wr_data[10:0]};

    assign ctrl_wr   = wr_en && (addr == ADDR_CTRL) && !busy;
    assign start_req = ctrl_wr && wr_data[CTRL_GO_BIT] && cfg_en
                       && (wr_data[CTRL_RD_BIT] || wr_data[CTRL_WR_BIT]);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_div <= DIV_W'(DIV_RESET);
            cfg_en  <= 1'b0;
            phy_q   <= '0;
            reg_q   <= '0;
            op_rd_q <= 1'b0;
            op_wr_q <= 1'b0;
            wdata_q <= '0;
        end else begin
            if (wr_en && addr == ADDR_CFG) begin
                cfg_div <= wr_data[DIV_W-1:0];
                cfg_en  <= wr_data[CFG_EN_BIT];
            end
            if (ctrl_wr) begin
                phy_q   <= wr_data[CTRL_PHY_LSB +: ADDR_W];
                reg_q   <= wr_data[CTRL_REG_LSB +: ADDR_W];
                op_rd_q <= wr_data[CTRL_RD_BIT];
                op_wr_q <= wr_data[CTRL_WR_BIT];
            end
            if (wr_en && addr == ADDR_WDATA)
                wdata_q <= wr_data[DATA_W-1:0];
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (addr)
            ADDR_CFG: begin
                rd_data[DIV_W-1:0]  = cfg_div;
                rd_data[CFG_EN_BIT] = cfg_en;
            end
            ADDR_CTRL: begin
                rd_data[CTRL_PHY_LSB +: ADDR_W] = phy_q;
                rd_data[CTRL_REG_LSB +: ADDR_W] = reg_q;
                rd_data[CTRL_RD_BIT]  = op_rd_q;
                rd_data[CTRL_WR_BIT]  = op_wr_q;
                rd_data[CTRL_RDY_BIT] = !busy;
            end
            ADDR_WDATA: rd_data[DATA_W-1:0] = wdata_q;
            ADDR_RDATA: rd_data[DATA_W-1:0] = rdata;
            default:    rd_data = '0;
        endcase
    end

    mdio_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .div   (cfg_div),
        .mdc   (mdc),
        .rise  (rise),
        .fall  (fall)
    );

    mdio_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start_req),
        .op_rd    (wr_data[CTRL_RD_BIT]),
        .phy_addr (wr_data[CTRL_PHY_LSB +: ADDR_W]),
        .reg_addr (wr_data[CTRL_REG_LSB +: ADDR_W]),
        .wdata    (wdata_q),
        .rise     (rise),
        .fall     (fall),
        .mdio_i   (mdio_i),
        .busy     (busy),
        .is_rd    (eng_rd),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .rdata    (rdata)
    );

endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk #(
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [1:0]        addr,
    input logic [31:0]       wr_data,
    input logic              mdc,
    input logic              mdio_o,
    input logic              mdio_oe,
    input logic              busy,
    input logic              eng_rd,
    input logic              cfg_en,
    input logic [ADDR_W-1:0] phy_q
);

    // R4
    ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd1 && wr_data[11] && cfg_en && !busy && (wr_data[15] || wr_data[14])) |=> busy);

    // R2
    mdc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);

    // R5
    mdio_fall_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$fell(mdc)) |-> $stable(mdio_o));

    // R6
    write_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !eng_rd) |-> mdio_oe);

    // R9
    no_start_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_en && !busy) |=> !busy);

    // R10
    fields_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en && addr == 2'd1) |=> $stable(phy_q));

endmodule

bind mdio_mgmt_ctrl mdio_mgmt_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .wr_data (wr_data),
    .mdc     (mdc),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe),
    .busy    (busy),
    .eng_rd  (eng_rd),
    .cfg_en  (cfg_en),
    .phy_q   (phy_q)
);

// File: tb/mdio_mgmt_ctrl_tb.sv
`timescale 1ns/1ps
module mdio_mgmt_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [1:0]  addr;
    logic [31:0] wr_data;
    logic [31:0] rd_data;
    logic        mdc, mdio_o, mdio_oe, mdio_i;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    mdio_mgmt_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // ---------------- behavioural model ----------------
    localparam logic [4:0] PHY_HERE = 5'd5;
    bit          m_en;
    int          m_div;
    bit          m_busy;
    int          m_t;
    int          m_half;
    bit          m_read;
    logic [63:0] m_frame;
    logic [15:0] m_resp;
    logic [15:0] m_rdata;

    function automatic logic [15:0] phy_value(input logic [4:0] ra);
        if (ra == 5'd1) return 16'h79AD;
        return {3'b101, ra, 8'h3C};
    endfunction

    function automatic logic phy_drive();
        int b;
        if (!m_busy || !m_read) return 1'b1;
        b = m_t / (2 * m_half);
        if (b < 47) return 1'b1;
        if (b == 47) return (m_resp == 16'hFFFF) ? 1'b1 : 1'b0;
        return m_resp[63 - b];
    endfunction

    assign mdio_i = mdio_oe ? mdio_o : phy_drive();

    always @(posedge clk) begin
        bit was_busy;
        cycles++;
        if (!rst_n) begin
            m_en = 0; m_div = 29; m_busy = 0; m_t = 0; m_half = 30; m_read = 0; m_rdata = 16'h0;
            m_resp = 16'hFFFF; m_frame = '1;
        end else begin
            was_busy = m_busy;
            if (m_busy) begin
                m_t++;
                if (m_t == 128 * m_half) begin
                    m_busy = 0;
                    if (m_read) m_rdata = m_resp;
                end
            end
            if (wr_en && addr == 2'd0) begin
                m_en  = wr_data[6];
                m_div = int'(wr_data[5:0]);
            end
            if (wr_en && addr == 2'd1 && !was_busy && wr_data[11] && m_en && (wr_data[15] || wr_data[14])) begin
                m_busy  = 1;
                m_t     = 0;
                m_half  = m_div + 1;
                m_read  = wr_data[15];
                m_frame = {32'hFFFF_FFFF, 2'b01, (m_read ? 2'b10 : 2'b01),
                           wr_data[28:24], wr_data[20:16], 2'b10, u_wdata_shadow};
                m_resp  = (wr_data[28:24] == PHY_HERE) ? phy_value(wr_data[20:16]) : 16'hFFFF;
            end
        end
    end

    // bench-side copy of the write-data word, kept from the stimulus
    logic [15:0] u_wdata_shadow;
    always @(posedge clk) begin
        if (!rst_n) u_wdata_shadow <= 16'h0;
        else if (wr_en && addr == 2'd2) u_wdata_shadow <= wr_data[15:0];
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // per-clock comparison, away from both clock edges
    always @(posedge clk) begin
        #3;
        if (rst_n) begin
            if (m_busy) begin
                int b;
                b = m_t / (2 * m_half);
                check("R2 mdc period", {31'b0, mdc}, {31'b0, ((m_t % (2 * m_half)) >= m_half)});
                check("R7 mdio_oe", {31'b0, mdio_oe}, {31'b0, !(m_read && b >= 46)});
                if (!(m_read && b >= 46))
                    check("R5 mdio_o bit", {31'b0, mdio_o}, {31'b0, m_frame[63 - b]});
            end else begin
                check("R9 idle mdc", {31'b0, mdc}, 32'd0);
                check("R9 idle oe", {31'b0, mdio_oe}, 32'd0);
            end
            if (addr == 2'd1 && !wr_en)
                check("R4 ready", {31'b0, rd_data[7]}, {31'b0, !m_busy});
        end
    end

    // ---------------- stimulus ----------------
    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        addr = a;
        #1 v = rd_data;
    endtask

    task automatic wait_ready();
        int n = 0;
        addr = 2'd1;
        do begin
            @(negedge clk); #1; n++;
        end while (!rd_data[7] && n < 20000);
    endtask

    function automatic logic [31:0] ctrl_word(input logic [4:0] p, input logic [4:0] r,
                                              input bit rd, input bit wr, input bit go);
        return {3'b0, p, 3'b0, r, rd, wr, 2'b0, go, 11'b0};
    endfunction

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        while (cycles < 150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        int found, nfound;
        wr_en = 0; addr = 2'd1; wr_data = 0; rst_n = 0;
        repeat (5) @(negedge clk);
        rst_n = 1;

        // R1 reset values
        bus_read(2'd0, v); check("R1 config reset", v, 32'h0000_001D);
        bus_read(2'd1, v); check("R1 control reset", v, 32'h0000_0080);
        bus_read(2'd3, v); check("R1 read-data reset", v, 32'h0);

        // R9 initiate while disabled; R3 field readback
        bus_write(2'd1, ctrl_word(5'd5, 5'd1, 1, 0, 1));
        repeat (20) @(negedge clk);
        bus_read(2'd1, v); check("R3 R9 control fields, no start", v, 32'h0501_8080);

        // R2 enable with default divisor
        bus_write(2'd0, 32'h0000_005D);
        bus_read(2'd0, v); check("R2 config readback", v, 32'h0000_005D);

        // R12 write-data readback
        bus_write(2'd2, 32'h0000_A5C3);
        bus_read(2'd2, v); check("R12 write-data readback", v, 32'h0000_A5C3);

        // R6 write frame at divisor 29, R4 ready drop
        bus_write(2'd1, ctrl_word(5'h12, 5'h0B, 0, 1, 1));
        bus_read(2'd1, v); check("R4 ready low after initiate", {31'b0, v[7]}, 32'd0);
        repeat (700) @(negedge clk);
        // R10 control write in mid-frame
        bus_write(2'd1, ctrl_word(5'h03, 5'h1F, 1, 0, 1));
        bus_read(2'd1, v); check("R10 fields held while busy", v, 32'h120B_4000);
        wait_ready();
        bus_read(2'd1, v); check("R4 ready back after frame", v, 32'h120B_4080);

        // R7 reads from a present PHY at divisor 2
        bus_write(2'd0, 32'h0000_0042);
        bus_write(2'd1, ctrl_word(5'd5, 5'd1, 1, 0, 1));
        wait_ready();
        bus_read(2'd3, v); check("R7 read reg 1", v, 32'h0000_79AD);
        bus_write(2'd1, ctrl_word(5'd5, 5'h1E, 1, 0, 1));
        wait_ready();
        bus_read(2'd3, v); check("R7 read reg 30", v, 32'h0000_BE3C);

        // R8 absent PHY
        bus_write(2'd1, ctrl_word(5'd9, 5'd1, 1, 0, 1));
        wait_ready();
        bus_read(2'd3, v); check("R8 absent PHY", v, 32'h0000_FFFF);

        // R11 no opcode, then both opcodes
        bus_write(2'd1, ctrl_word(5'd5, 5'd2, 0, 0, 1));
        repeat (3) @(negedge clk);
        bus_read(2'd1, v); check("R11 no-op initiate ignored", {31'b0, v[7]}, 32'd1);
        bus_read(2'd3, v); check("R11 read data untouched", v, 32'h0000_FFFF);
        bus_write(2'd1, ctrl_word(5'd5, 5'd2, 1, 1, 1));
        wait_ready();
        bus_read(2'd3, v); check("R11 both opcodes read", v, 32'h0000_A23C);

        // R12 read-data word is read-only
        bus_write(2'd3, 32'h0000_1234);
        bus_read(2'd3, v); check("R12 read-data write ignored", v, 32'h0000_A23C);

        // R8 scan 31 down to 0 at divisor 0
        bus_write(2'd0, 32'h0000_0040);
        found = -1; nfound = 0;
        for (int i = 31; i >= 0; i--) begin
            bus_write(2'd1, ctrl_word(5'(i), 5'd1, 1, 0, 1));
            wait_ready();
            bus_read(2'd3, v);
            if (v[15:0] != 16'hFFFF && (v[15:0] & 16'h1808) == 16'h1808) begin
                found = i; nfound++;
            end
        end
        check("R8 scan address", 32'(found), 32'd5);
        check("R8 scan count", 32'(nfound), 32'd1);
        check("R7 model read data", {16'h0, v[15:0]}, {16'h0, m_rdata});

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule